// File: doc/BRIEF.md
# 4B5B Receive Symbol Decoder

This block sits behind a descrambler that has already found the 5-bit word boundaries. Each clock it takes one aligned code group and produces the nibble-wide receive side of a media-independent interface: a data nibble, a data-valid flag, a carrier flag and a receive-error flag. It searches idle traffic for the two-symbol start delimiter and replays it as two preamble nibbles of value 5. It then decodes data code groups until the two-symbol end delimiter arrives. The end delimiter is presented as zero nibbles with carrier and data-valid already low.

Faults are reported in two ways. A malformed start delimiter, a malformed or missing end delimiter and an unknown code group inside a packet each set a separate sticky status bit. A one-cycle clear input resets all three. Inside a packet, an error also raises the receive-error flag for the cycle in which the offending nibble is presented. A link-fail input forces the receive outputs inactive and returns the decoder to delimiter search. Every output is registered, so each result appears one clock after the code group that caused it.

Top module: `rx_symbol_decoder`

## Requirements
- R1: Out of reset, and whenever no packet is in progress, rx_dv_o and crs_o are low and rxd_o is 0000.
- R2: The start pair J (11000) followed by K (10001) is presented as two nibbles 0101 with rx_dv_o and crs_o high, each one cycle after its code group.
- R3: Inside a packet, each of the sixteen data code groups is presented one cycle later as its nibble, with rx_dv_o high. The codes for 0 through F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: The code T (01101) inside a packet ends it. Its output cycle and the cycle for the following R (00111) show rx_dv_o and crs_o low and rxd_o 0000.
- R5: Inside a packet, any code group that is neither data, T nor idle (11111) is presented as 0000 with rx_dv_o high and rx_er_o high for that one cycle, and it sets err_code_o (status bit 2). The packet continues.
- R6: A J followed by anything other than K is presented as 0000 with rx_dv_o high and rx_er_o high for that cycle. It sets err_start_o (status bit 0), and the decoder returns to start search.
- R7: An idle code group inside a packet closes the packet. Its output cycle shows rx_er_o high, rx_dv_o high and rxd_o 0000, and err_end_o (status bit 1) is set. The next cycle is idle.
- R8: A T followed by anything other than R sets err_end_o without raising rx_er_o, and the decoder returns to start search.
- R9: While link_fail_i is high, the next cycle shows all receive outputs low. The decoder is back in start search, and no status bit is set.
- R10: Status bits stay set until stat_clr_i is high for a cycle. A new error in the clearing cycle wins over the clear.
- R11: Outside a packet, code groups other than J change no output and set no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 5 | Aligned code group, one per clock |
| link_fail_i | input | 1 | Link down; forces receive outputs inactive |
| stat_clr_i | input | 1 | One-cycle clear of the sticky status bits |
| rxd_o | output | 4 | Receive nibble |
| rx_dv_o | output | 1 | Receive data valid |
| crs_o | output | 1 | Carrier sense |
| rx_er_o | output | 1 | Receive error, same cycle as the faulty nibble |
| err_start_o | output | 1 | Sticky start-delimiter error |
| err_end_o | output | 1 | Sticky end-delimiter error |
| err_code_o | output | 1 | Sticky invalid code-group error |

## Verification
A framer stuck in the wrong state shows up at the ports within one or two symbols. It may miss a packet, so no 0101 pair appears after J/K. It may keep rx_dv_o high through the end delimiter, or it may count a valid K as an error, which raises rx_er_o and the start status bit at once. A wrong entry in the decode table is visible on rxd_o one cycle after that code group. Random frames cover every data code, injected bad symbols and link drops. Every cycle is compared against a bench model of the requirements, so any divergence is reported in the cycle it first appears.

// File: rtl/rx4b5b_pkg.sv
package rx4b5b_pkg;
  localparam int CODE_W = 5;
  localparam int NIB_W  = 4;
  localparam int N_ERR  = 3;

  localparam logic [CODE_W-1:0] C_IDLE = 5'b11111;
  localparam logic [CODE_W-1:0] C_J    = 5'b11000;
  localparam logic [CODE_W-1:0] C_K    = 5'b10001;
  localparam logic [CODE_W-1:0] C_T    = 5'b01101;
  localparam logic [CODE_W-1:0] C_R    = 5'b00111;

  localparam logic [NIB_W-1:0] NIB_PRE = 4'h5;

  localparam int EB_START = 0;
  localparam int EB_END   = 1;
  localparam int EB_CODE  = 2;

  typedef enum logic [2:0] {
    SK_DATA, SK_IDLE, SK_J, SK_K, SK_T, SK_R, SK_BAD
  } sym_kind_e;

  typedef struct packed {
    sym_kind_e          kind;
    logic [NIB_W-1:0]   nib;
  } sym_t;

  typedef enum logic [1:0] {
    FS_HUNT, FS_GOT_J, FS_FRAME, FS_GOT_T
  } fstate_e;
endpackage

// File: rtl/sym_classify.sv
module sym_classify
  import rx4b5b_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output sym_t              sym_o
);
  always_comb begin
    sym_o.kind = SK_DATA;
    sym_o.nib  = '0;
    unique case (code_i)
      5'b11110: sym_o.nib = 4'h0;
      5'b01001: sym_o.nib = 4'h1;
      5'b10100: sym_o.nib = 4'h2;
      5'b10101: sym_o.nib = 4'h3;
      5'b01010: sym_o.nib = 4'h4;
      5'b01011: sym_o.nib = 4'h5;
      5'b01110: sym_o.nib = 4'h6;
      5'b01111: sym_o.nib = 4'h7;
      5'b10010: sym_o.nib = 4'h8;
      5'b10011: sym_o.nib = 4'h9;
      5'b10110: sym_o.nib = 4'hA;
      5'b10111: sym_o.nib = 4'hB;
      5'b11010: sym_o.nib = 4'hC;
      5'b11011: sym_o.nib = 4'hD;
      5'b11100: sym_o.nib = 4'hE;
      5'b11101: sym_o.nib = 4'hF;
      C_IDLE:   sym_o.kind = SK_IDLE;
      C_J:      sym_o.kind = SK_J;
      C_K:      sym_o.kind = SK_K;
      C_T:      sym_o.kind = SK_T;
      C_R:      sym_o.kind = SK_R;
      default:  sym_o.kind = SK_BAD;
    endcase
  end
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rx4b5b_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             link_fail_i,
  input  sym_t             sym_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             dv_o,
  output logic             er_o,
  output logic [N_ERR-1:0] err_set_o
);
  fstate_e          st_q, st_d;
  logic [NIB_W-1:0] nib_d;
  logic             dv_d, er_d;
  logic [N_ERR-1:0] set_d;

  always_comb begin
    st_d  = st_q;
    nib_d = '0;
    dv_d  = 1'b0;
    er_d  = 1'b0;
    set_d = '0;
    unique case (st_q)
      FS_HUNT: begin
        if (sym_i.kind == SK_J) begin
          st_d  = FS_GOT_J;
          nib_d = NIB_PRE;
          dv_d  = 1'b1;
        end
      end
      FS_GOT_J: begin
        dv_d = 1'b1;
        if (sym_i.kind == SK_K) begin
          st_d  = FS_FRAME;
          nib_d = NIB_PRE;
        end else begin
          st_d            = FS_HUNT;
          er_d            = 1'b1;
          set_d[EB_START] = 1'b1;
        end
      end
      FS_FRAME: begin
        unique case (sym_i.kind)
          SK_DATA: begin
            dv_d  = 1'b1;
            nib_d = sym_i.nib;
          end
          SK_T: st_d = FS_GOT_T;
          SK_IDLE: begin
            st_d          = FS_HUNT;
            dv_d          = 1'b1;
            er_d          = 1'b1;
            set_d[EB_END] = 1'b1;
          end
          default: begin
            dv_d           = 1'b1;
            er_d           = 1'b1;
            set_d[EB_CODE] = 1'b1;
          end
        endcase
      end
      FS_GOT_T: begin
        st_d = FS_HUNT;
        if (sym_i.kind != SK_R) set_d[EB_END] = 1'b1;
      end
      default: st_d = FS_HUNT;
    endcase
  end

  assign err_set_o = (rst || link_fail_i) ? '0 : set_d;

  always_ff @(posedge clk) begin
    if (rst || link_fail_i) begin
      st_q  <= FS_HUNT;
      rxd_o <= '0;
      dv_o  <= 1'b0;
      er_o  <= 1'b0;
    end else begin
      st_q  <= st_d;
      rxd_o <= nib_d;
      dv_o  <= dv_d;
      er_o  <= er_d;
    end
  end

  assert_jk_preamble_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == FS_GOT_J && sym_i.kind == SK_K && !link_fail_i) |=> (dv_o && rxd_o == NIB_PRE));

  assert_bad_k_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == FS_GOT_J && sym_i.kind != SK_K && !link_fail_i) |=> (er_o && st_q == FS_HUNT));

  assert_t_closes_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == FS_FRAME && sym_i.kind == SK_T && !link_fail_i) |=> (!dv_o && rxd_o == '0));

  assert_single_err_class_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(err_set_o) <= 1);
endmodule

// File: rtl/err_sticky.sv
module err_sticky
  import rx4b5b_pkg::*;
#(
  parameter int N = N_ERR
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             flag_o[g] <= 1'b0;
      else if (set_i[g])   flag_o[g] <= 1'b1;
      else if (clr_i)      flag_o[g] <= 1'b0;
    end

    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (rst)
      ($past(flag_o[g]) && !$past(clr_i)) |-> flag_o[g]);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
      set_i[g] |=> flag_o[g]);
  end
endmodule

// File: rtl/rx_symbol_decoder.sv
module rx_symbol_decoder
  import rx4b5b_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  code_i,
  input  logic        link_fail_i,
  input  logic        stat_clr_i,
  output logic [3:0]  rxd_o,
  output logic        rx_dv_o,
  output logic        crs_o,
  output logic        rx_er_o,
  output logic        err_start_o,
  output logic        err_end_o,
  output logic        err_code_o
);
  sym_t             sym;
  logic             dv;
  logic [N_ERR-1:0] err_set, err_flag;

  sym_classify u_cls (
    .code_i (code_i),
    .sym_o  (sym)
  );

  rx_framer u_frm (
    .clk        (clk),
    .rst        (rst),
    .link_fail_i(link_fail_i),
    .sym_i      (sym),
    .rxd_o      (rxd_o),
    .dv_o       (dv),
    .er_o       (rx_er_o),
    .err_set_o  (err_set)
  );

  err_sticky #(.N(N_ERR)) u_st (
    .clk   (clk),
    .rst   (rst),
    .clr_i (stat_clr_i),
    .set_i (err_set),
    .flag_o(err_flag)
  );

  assign rx_dv_o     = dv;
  assign crs_o       = dv;
  assign err_start_o = err_flag[EB_START];
  assign err_end_o   = err_flag[EB_END];
  assign err_code_o  = err_flag[EB_CODE];

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !rx_dv_o |-> (rxd_o == 4'h0 && !rx_er_o));

  assert_link_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $past(link_fail_i) |-> (!crs_o && !rx_dv_o && !rx_er_o));

  assert_err_flagged_R5: assert property (@(posedge clk) disable iff (rst)
    rx_er_o |-> (err_start_o || err_end_o || err_code_o));
endmodule

// File: tb/sim_rx_symbol_decoder.sv
module sim_rx_symbol_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] code = 5'b11111;
  logic       lf = 1'b0;
  logic       clr = 1'b0;
  logic [3:0] rxd;
  logic       dv, crs, er, e_s, e_e, e_c;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  int         ms = 0;
  logic [2:0] mstat = 3'b000;
  logic [3:0] x_rxd;
  logic       x_dv, x_er;
  string      tag;

  always #10 clk = ~clk;

  rx_symbol_decoder u0 (
    .clk(clk), .rst(rst), .code_i(code), .link_fail_i(lf), .stat_clr_i(clr),
    .rxd_o(rxd), .rx_dv_o(dv), .crs_o(crs), .rx_er_o(er),
    .err_start_o(e_s), .err_end_o(e_e), .err_code_o(e_c)
  );

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001; 4'h2: return 5'b10100;
      4'h3: return 5'b10101; 4'h4: return 5'b01010; 4'h5: return 5'b01011;
      4'h6: return 5'b01110; 4'h7: return 5'b01111; 4'h8: return 5'b10010;
      4'h9: return 5'b10011; 4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011; 4'hE: return 5'b11100;
      default: return 5'b11101;
    endcase
  endfunction

  function automatic bit is_data(input logic [4:0] c, output logic [3:0] n);
    for (int i = 0; i < 16; i++)
      if (enc(i[3:0]) == c) begin n = i[3:0]; return 1'b1; end
    n = 4'h0;
    return 1'b0;
  endfunction

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", t, what, act, exp, cyc);
    end
  endtask

  task automatic step(input logic [4:0] c, input logic l, input logic cl);
    logic [2:0] set;
    logic [3:0] n;
    code = c; lf = l; clr = cl;
    x_rxd = 4'h0; x_dv = 1'b0; x_er = 1'b0; set = 3'b000;
    tag = "R11";
    if (l) begin
      ms = 0; tag = "R9";
    end else begin
      case (ms)
        0: if (c == 5'b11000) begin x_dv = 1; x_rxd = 4'h5; ms = 1; tag = "R2"; end
        1: begin
          x_dv = 1;
          if (c == 5'b10001) begin x_rxd = 4'h5; ms = 2; tag = "R2"; end
          else begin x_er = 1; set[0] = 1; ms = 0; tag = "R6"; end
        end
        2: begin
          if (is_data(c, n)) begin x_dv = 1; x_rxd = n; tag = "R3"; end
          else if (c == 5'b01101) begin ms = 3; tag = "R4"; end
          else if (c == 5'b11111) begin x_dv = 1; x_er = 1; set[1] = 1; ms = 0; tag = "R7"; end
          else begin x_dv = 1; x_er = 1; set[2] = 1; tag = "R5"; end
        end
        default: begin
          ms = 0;
          if (c == 5'b00111) tag = "R4";
          else begin set[1] = 1; tag = "R8"; end
        end
      endcase
    end
    mstat = (mstat & ~{3{cl}}) | set;
    @(negedge clk);
    chk(tag, "rxd", rxd, x_rxd);
    chk(tag, "rx_dv", dv, x_dv);
    chk(tag, "crs", crs, x_dv);
    chk(tag, "rx_er", er, x_er);
    chk("R10", "status", {e_c, e_e, e_s}, mstat);
  endtask

  task automatic frame(input int len, input int inject);
    step(5'b11000, 0, 0);
    step(5'b10001, 0, 0);
    for (int i = 0; i < len; i++) begin
      if (inject == 1 && i == len / 2) step(5'b00100, 0, 0);
      else step(enc($urandom_range(15)), 0, 0);
    end
    if (inject == 2) step(5'b11111, 0, 0);
    else if (inject == 3) begin step(5'b01101, 0, 0); step(5'b01001, 0, 0); end
    else begin step(5'b01101, 0, 0); step(5'b00111, 0, 0); end
    for (int i = 0; i < 2 + $urandom_range(3); i++) step(5'b11111, 0, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1", "reset rx_dv", dv, 0);
    chk("R1", "reset rxd", rxd, 0);
    chk("R10", "reset status", {e_c, e_e, e_s}, 0);
    rst = 1'b0;
    // R11: stray symbols outside a packet
    step(5'b10001, 0, 0); step(5'b01101, 0, 0); step(5'b00100, 0, 0); step(5'b00000, 0, 0);
    // R2 R3 R4: clean frame walking all data codes
    step(5'b11000, 0, 0); step(5'b10001, 0, 0);
    for (int i = 0; i < 16; i++) step(enc(i[3:0]), 0, 0);
    step(5'b01101, 0, 0); step(5'b00111, 0, 0); step(5'b11111, 0, 0);
    // R6: J not followed by K, then J J
    step(5'b11000, 0, 0); step(5'b11111, 0, 0); step(5'b11111, 0, 0);
    step(5'b11000, 0, 0); step(5'b11000, 0, 0); step(5'b11111, 0, 0);
    // R10: clear, and set beating clear in the same cycle
    step(5'b11111, 0, 1);
    step(5'b11000, 0, 0); step(5'b00000, 0, 1); step(5'b11111, 0, 0);
    step(5'b11111, 0, 1);
    // R5: bad code mid packet, packet continues; R8: T without R
    frame(4, 1); frame(3, 3);
    // R7: idle ends packet early
    frame(5, 2);
    step(5'b11111, 0, 1);
    // R9: link fail in mid packet, with J on the wire
    step(5'b11000, 0, 0); step(5'b10001, 0, 0); step(enc(4'h9), 0, 0);
    step(5'b11000, 1, 0); step(5'b10001, 1, 0); step(enc(4'h3), 0, 0);
    step(5'b11111, 0, 0);
    // random mix
    for (int f = 0; f < 300; f++) begin
      if ($urandom_range(19) == 0) step(5'b11000, 1, 0);
      if ($urandom_range(9) == 0) step(5'b11111, 0, 1);
      if ($urandom_range(7) == 0) step($urandom_range(31), 0, 0);
      frame(1 + $urandom_range(20), ($urandom_range(3) == 0) ? $urandom_range(1, 3) : 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule